// File: doc/BRIEF.md
# Interrupt Enable and Flag Register

This block is the 8-bit interrupt control register of a small microcontroller core. It sits on a simple register bus and holds a master enable, a peripheral-group enable, three per-source enables and three sticky event flags. Hardware sets the flags from three sources: a one-cycle timer rollover pulse, a rising edge on an external interrupt pin, and a change on any of six general-purpose inputs whose per-pin change-detect enable is set. Software clears a flag only by writing 0 to it.

The register answers at two bus addresses that share one set of storage. A single interrupt request goes to the core. It is raised when the master enable is set and at least one of these holds: an enabled flag is set, or the peripheral-group enable is set while the peripheral group reports a pending request on its one input. The timer, the pad logic, the vectoring and the peripheral registers are outside the block.

Top module: `intr_ctl_reg`

## Requirements
- R1: After reset all eight register bits read as 0 and `irqOut` is 0.
- R2: A write at address 0x0B stores all eight bits of `busWdata`, and a read returns them. Bit positions: 7 master enable, 6 peripheral enable, 5 timer enable, 4 pin enable, 3 port enable, 2 timer flag, 1 pin flag, 0 port flag.
- R3: Address 0x8B reads and writes the same storage as 0x0B. Writes to any other address change nothing. Reads at any other address return 0.
- R4: A high `tmrRollover` at a clock edge sets bit 2 at that edge, whatever the enable bits hold.
- R5: `extPin` passes through two synchronizing flops. Bit 1 sets at the third clock edge after a rising transition of `extPin`, whatever the enable bits hold. A falling transition sets nothing.
- R6: Bit 0 sets at the third clock edge after a change on any `gpioPins` bit whose matching `gpioDetectEn` bit is 1. A change on a pin whose enable is 0 sets nothing.
- R7: Hardware never clears a flag. A flag stays 1 until a bus write puts 0 in its bit.
- R8: When a set event and a bus write of 0 reach the same flag at the same edge, the flag ends up 1.
- R9: `irqOut` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periphPending`)). It is combinational from the register and `periphPending`.
- R10: With bit 7 at 0, `irqOut` stays 0 whatever the other bits and `periphPending` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register bus address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| tmrRollover | input | 1 | One-cycle pulse when the timer wraps to zero |
| extPin | input | 1 | Asynchronous external interrupt pin |
| gpioPins | input | 6 | Asynchronous general-purpose inputs |
| gpioDetectEn | input | 6 | Per-pin change-detect enables |
| periphPending | input | 1 | Combined pending request of the peripheral group |
| irqOut | output | 1 | Interrupt request to the core |

## Verification
The assertions check on every cycle that flags only fall through a decoded write, that a rollover pulse always leaves the timer flag set (also against a clearing write), that either address reads the stored value and other addresses read 0, and that the request never rises without the master enable and a matching cause. The bench scenarios cover the things a single-cycle property cannot show. These are the three-edge latency of the synchronized pin and port paths, the fact that falling edges and masked pins set nothing, and the full request equation, which a reference model checks against long random mixes of writes, events and mirrored addresses.

// File: rtl/intr_ctl_pkg.sv
package intr_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_N   = 3;
  localparam int EN_N     = REG_W - FLAG_N;

  // bit positions that the core and software decode
  localparam int BIT_MASTER = 7;
  localparam int BIT_PERIPH = 6;
  localparam int BIT_TICKEN = 5;
  localparam int BIT_PINEN  = 4;
  localparam int BIT_PORTEN = 3;
  localparam int BIT_TICKF  = 2;
  localparam int BIT_PINF   = 1;
  localparam int BIT_PORTF  = 0;

  typedef struct packed {
    logic wrHit;
    logic setTick;
    logic setPin;
    logic setPort;
  } ctlStrobes_t;
endpackage

// File: rtl/intr_ctl_event.sv
module intr_ctl_event
  import intr_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int GPIO_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 8'h8B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              tmrRollover,
  input  logic              extPin,
  input  logic [GPIO_W-1:0] gpioPins,
  input  logic [GPIO_W-1:0] gpioDetectEn,
  output logic              addrHit,
  output ctlStrobes_t       strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] pinStage;
  logic                   pinPrev;
  logic [GPIO_W-1:0]      portStage [SYNC_STAGES];
  logic [GPIO_W-1:0]      portPrev;

  // two-flop (or deeper) synchronizer for the external pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinStage <= '0;
      pinPrev  <= 1'b0;
    end else begin
      pinStage <= {pinStage[SYNC_STAGES-2:0], extPin};
      pinPrev  <= pinStage[LAST];
    end
  end

  // synchronizer chain for the port inputs, one stage per generate step
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_portSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) portStage[s] <= '0;
      else if (s == 0) portStage[s] <= gpioPins;
      else portStage[s] <= portStage[(s == 0) ? 0 : s - 1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portPrev <= '0;
    else portPrev <= portStage[LAST];
  end

  logic [GPIO_W-1:0] portDelta;

  always_comb begin
    addrHit           = (busAddr == BASE_ADDR) || (busAddr == MIRROR_ADDR);
    portDelta         = (portStage[LAST] ^ portPrev) & gpioDetectEn;
    strobes.wrHit     = busWe && addrHit;
    strobes.setTick   = tmrRollover;
    strobes.setPin    = pinStage[LAST] && !pinPrev;
    strobes.setPort   = |portDelta;
  end
endmodule

// File: rtl/intr_ctl_datapath.sv
module intr_ctl_datapath
  import intr_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             addrHit,
  input  logic [REG_W-1:0] busWdata,
  input  logic             periphPending,
  output logic [REG_W-1:0] busRdata,
  output logic [REG_W-1:0] ctlReg,
  output logic             irqOut
);
  logic [EN_N-1:0]   enQ;
  logic [FLAG_N-1:0] flagQ;
  logic [FLAG_N-1:0] flagNext;
  logic [FLAG_N-1:0] setVec;

  assign setVec = {strobes.setTick, strobes.setPin, strobes.setPort};

  // per-flag next state: a hardware set wins over a same-cycle clear
  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    assign flagNext[f] = setVec[f] | (strobes.wrHit ? busWdata[f] : flagQ[f]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      flagQ <= '0;
    end else begin
      if (strobes.wrHit) enQ <= busWdata[REG_W-1:FLAG_N];
      flagQ <= flagNext;
    end
  end

  logic srcReq;

  always_comb begin
    ctlReg   = {enQ, flagQ};
    busRdata = addrHit ? ctlReg : '0;
    srcReq   = (ctlReg[BIT_TICKEN] & ctlReg[BIT_TICKF])
             | (ctlReg[BIT_PINEN]  & ctlReg[BIT_PINF])
             | (ctlReg[BIT_PORTEN] & ctlReg[BIT_PORTF])
             | (ctlReg[BIT_PERIPH] & periphPending);
    irqOut   = ctlReg[BIT_MASTER] & srcReq;
  end
endmodule

// File: rtl/intr_ctl_reg.sv
module intr_ctl_reg
  import intr_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int GPIO_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 8'h8B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              tmrRollover,
  input  logic              extPin,
  input  logic [GPIO_W-1:0] gpioPins,
  input  logic [GPIO_W-1:0] gpioDetectEn,
  input  logic              periphPending,
  output logic              irqOut
);
  ctlStrobes_t      strobes;
  logic             addrHit;
  logic [REG_W-1:0] ctlReg;

  intr_ctl_event #(
    .ADDR_W(ADDR_W), .GPIO_W(GPIO_W), .SYNC_STAGES(SYNC_STAGES),
    .BASE_ADDR(BASE_ADDR), .MIRROR_ADDR(MIRROR_ADDR)
  ) event_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .tmrRollover(tmrRollover), .extPin(extPin), .gpioPins(gpioPins),
    .gpioDetectEn(gpioDetectEn), .addrHit(addrHit), .strobes(strobes)
  );

  intr_ctl_datapath datapath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrHit(addrHit),
    .busWdata(busWdata), .periphPending(periphPending),
    .busRdata(busRdata), .ctlReg(ctlReg), .irqOut(irqOut)
  );
endmodule

// File: rtl/intr_ctl_checker.sv
module intr_ctl_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busAddr,
  input logic       busWe,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       tmrRollover,
  input logic       periphPending,
  input logic       irqOut,
  input logic [7:0] ctlReg
);
  logic hit;
  logic wr;
  assign hit = (busAddr == 8'h0B) || (busAddr == 8'h8B);
  assign wr  = busWe && hit;

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wr |=> ctlReg[7:3] == $past(busWdata[7:3])); // R2
  AST_READ_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> busRdata == ctlReg); // R3
  AST_READ_MISS: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> busRdata == 8'h00); // R3
  AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    tmrRollover |=> ctlReg[2]); // R4
  AST_TICK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[2] && !wr |=> ctlReg[2]); // R7
  AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[1] && !wr |=> ctlReg[1]); // R7
  AST_PORT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[0] && !wr |=> ctlReg[0]); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    wr && !busWdata[2] && tmrRollover |=> ctlReg[2]); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((ctlReg[5] && ctlReg[2]) || (ctlReg[4] && ctlReg[1]) ||
                (ctlReg[3] && ctlReg[0]) || (ctlReg[6] && periphPending))); // R9
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReg[7] |-> !irqOut); // R10
endmodule

bind intr_ctl_reg intr_ctl_checker chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .tmrRollover(tmrRollover),
  .periphPending(periphPending), .irqOut(irqOut), .ctlReg(ctlReg)
);

// File: tb/intr_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module intr_ctl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       tmrRollover = 1'b0;
  logic       extPin = 1'b0;
  logic [5:0] gpioPins = 6'h00;
  logic [5:0] gpioDetectEn = 6'h00;
  logic       periphPending = 1'b0;
  logic       irqOut;

  int errCount = 0;
  int chkCount = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] mReg = 8'h00;
  logic mS1 = 0, mS2 = 0, mPrev = 0;
  logic [5:0] mG1 = 0, mG2 = 0, mGPrev = 0;

  always #2.5 clk = ~clk;

  intr_ctl_reg dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tmrRollover(tmrRollover),
    .extPin(extPin), .gpioPins(gpioPins), .gpioDetectEn(gpioDetectEn),
    .periphPending(periphPending), .irqOut(irqOut)
  );

  function automatic logic isHit(logic [7:0] a);
    return (a == 8'h0B) || (a == 8'h8B);
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] a, logic [7:0] r);
    return isHit(a) ? r : 8'h00;
  endfunction

  function automatic logic expIrq(logic [7:0] r, logic p);
    return r[7] & ((r[5] & r[2]) | (r[4] & r[1]) | (r[3] & r[0]) | (r[6] & p));
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock edge; model updated from the inputs held at that edge
  task automatic tick();
    logic setT, setP, setG, wr;
    logic [7:0] nxt;
    @(posedge clk);
    setT = tmrRollover;
    setP = mS2 & ~mPrev;
    setG = |((mG2 ^ mGPrev) & gpioDetectEn);
    wr   = busWe && isHit(busAddr);
    nxt  = wr ? busWdata : mReg;
    nxt[2] = nxt[2] | setT;
    nxt[1] = nxt[1] | setP;
    nxt[0] = nxt[0] | setG;
    mPrev = mS2; mS2 = mS1; mS1 = extPin;
    mGPrev = mG2; mG2 = mG1; mG1 = gpioPins;
    mReg = nxt;
    @(negedge clk);
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    busAddr = a; busWe = 1'b1; busWdata = d;
    tick();
    busWe = 1'b0; busAddr = 8'h0B;
    #1;
  endtask

  task automatic readAt(string req, logic [7:0] a, logic [7:0] exp);
    busAddr = a; busWe = 1'b0;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic checkIrq(string req, logic exp);
    #1;
    check(req, {7'h0, irqOut}, {7'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_0B8B));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readAt("R1 reset read", 8'h0B, 8'h00);
    checkIrq("R1 reset irq", 1'b0);

    // R2: full write/read at the base address
    busWrite(8'h0B, 8'hF8);
    readAt("R2 write base", 8'h0B, 8'hF8);
    // R3: mirror address shares storage
    readAt("R3 read mirror", 8'h8B, 8'hF8);
    busWrite(8'h8B, 8'h00);
    readAt("R3 write mirror", 8'h0B, 8'h00);
    busWrite(8'h0C, 8'h55);
    readAt("R3 other addr no write", 8'h0B, 8'h00);
    busWrite(8'h0B, 8'h3A);
    readAt("R3 other addr reads zero", 8'h0C, 8'h00);
    busWrite(8'h0B, 8'h00);

    // R4: timer flag with all enables off
    tmrRollover = 1'b1;
    tick();
    tmrRollover = 1'b0;
    readAt("R4 tick flag set", 8'h0B, 8'h04);
    checkIrq("R10 no irq with enables off", 1'b0);
    repeat (5) tick();
    readAt("R7 tick flag sticky", 8'h0B, 8'h04);
    busWrite(8'h0B, 8'h00);
    readAt("R7 write zero clears", 8'h0B, 8'h00);

    // R5: pin rising edge, three-edge latency
    extPin = 1'b1;
    tick(); tick();
    readAt("R5 pin flag not yet", 8'h0B, 8'h00);
    tick();
    readAt("R5 pin flag at third edge", 8'h0B, 8'h02);
    busWrite(8'h0B, 8'h00);
    extPin = 1'b0;
    repeat (4) tick();
    readAt("R5 falling edge ignored", 8'h0B, 8'h00);

    // R6: port change with per-pin enables
    gpioDetectEn = 6'b000001;
    gpioPins = 6'b100000;
    repeat (4) tick();
    readAt("R6 masked pin ignored", 8'h0B, 8'h00);
    gpioPins = 6'b100001;
    tick(); tick();
    readAt("R6 port flag not yet", 8'h0B, 8'h00);
    tick();
    readAt("R6 port flag at third edge", 8'h0B, 8'h01);
    busWrite(8'h0B, 8'h00);

    // R8: set and clear in the same cycle
    tmrRollover = 1'b1;
    busWrite(8'h0B, 8'h00);
    tmrRollover = 1'b0;
    readAt("R8 set wins over clear", 8'h0B, 8'h04);

    // R9 / R10: request gating
    busWrite(8'h0B, 8'hA4);
    checkIrq("R9 timer source irq", 1'b1);
    busWrite(8'h0B, 8'h24);
    checkIrq("R10 master off blocks", 1'b0);
    periphPending = 1'b1;
    busWrite(8'h0B, 8'hC0);
    checkIrq("R9 peripheral irq", 1'b1);
    busWrite(8'h0B, 8'h80);
    checkIrq("R9 peripheral enable off", 1'b0);
    busWrite(8'h0B, 8'h40);
    checkIrq("R10 master off peripheral", 1'b0);
    periphPending = 1'b0;
    busWrite(8'h0B, 8'h00);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 3);
      busAddr = (sel == 0) ? 8'h0B : (sel == 1) ? 8'h8B : 8'($urandom);
      busWe = ($urandom_range(0, 5) == 0);
      busWdata = 8'($urandom);
      tmrRollover = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) extPin = ~extPin;
      if ($urandom_range(0, 7) == 0) gpioPins = 6'($urandom);
      if ($urandom_range(0, 31) == 0) gpioDetectEn = 6'($urandom);
      periphPending = $urandom_range(0, 1) == 1;
      #1;
      check("R3 random read", busRdata, expRead(busAddr, mReg));
      check("R9 random irq", {7'h0, irqOut}, {7'h0, expIrq(mReg, periphPending)});
      tick();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule